// File: doc/BRIEF.md
# Translating DMA Channel Sequencer

This block sequences one DMA channel. Software programs five 32-bit words through a simple write/select register port: a control word, a remaining byte count, a logical start address, the base of a page table in memory and the size of that table in bytes. A device asks to move a burst by raising a request with a direction and a length. The block accepts the request only while idle. It first checks that the channel is enabled and that the direction agrees with the channel's programmed direction.

When the checks pass, the block clips the length to the remaining count. It maps the logical page onto a physical frame by fetching one 8-byte entry from the in-memory table over a valid/ready read port. It then issues a single physical transfer request and, when that request is accepted, charges the moved length against the count. Each outcome is recorded in three sticky-until-next-burst flag bits of the control word. Moving data is left to whoever accepts the transfer request.

Top module: `dma_xlat_channel`

## Requirements
- R1: After reset all five registers read as zero, `req_ready` is 1, and `chan_err`, `tbl_rd_valid` and `xfer_valid` are 0.
- R2: A write with `reg_wr` high stores `reg_wdata` in the register chosen by `reg_sel` (0 control, 1 count, 2 logical address, 3 table base, 4 table size). `reg_rdata` returns the selected register in the same cycle.
- R3: `req_ready` is high exactly when no burst is in progress. Accepting a burst clears control bits 8, 9 and 10.
- R4: If control bit 0 (enable) is 0, or control bit 1 (1 = memory to device) differs from `req_to_dev`, the block sets control bit 9 and raises `chan_err` for the one cycle after acceptance. It then issues neither a table read nor a transfer.
- R5: The page index is the logical address shifted right by 12. An index not below (table size >> 3) sets control bit 10, and no table read or transfer follows.
- R6: The table read address is (table base AND 0x7FFFFFFF) + index × 8.
- R7: An error response to the table read sets control bit 10, and no transfer follows.
- R8: The transfer address is the entry word with its low 12 bits cleared, OR the low 12 bits of the logical address. The length is the smaller of `req_len` and the count. The direction equals `req_to_dev`.
- R9: When the transfer request is accepted, the count drops by the transfer length and control bit 8 is set.
- R10: `tbl_rd_valid` and `xfer_valid`, once raised, stay high with a stable address until accepted. At most one of them is high at a time.
- R11: When a software write and a hardware update target the same register in the same cycle, the hardware update is kept and the write is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| req_valid | input | 1 | Burst request |
| req_ready | output | 1 | Block idle, burst accepted |
| req_to_dev | input | 1 | Requested direction, 1 = memory to device |
| req_len | input | 16 | Requested burst length in bytes |
| tbl_rd_valid | output | 1 | Table read request |
| tbl_rd_ready | input | 1 | Table read accepted |
| tbl_rd_addr | output | 32 | Table entry address |
| tbl_rsp_valid | input | 1 | Table read response |
| tbl_rsp_err | input | 1 | Table read failed |
| tbl_rsp_data | input | 32 | First word of the table entry |
| xfer_valid | output | 1 | Physical transfer request |
| xfer_ready | input | 1 | Transfer accepted |
| xfer_addr | output | 32 | Physical start address |
| xfer_len | output | 16 | Transfer length in bytes |
| xfer_to_dev | output | 1 | Transfer direction |
| chan_err | output | 1 | One-cycle enable/direction error pulse |

## Verification
Two functions can collide in the same cycle: a software register write and the sequencer's own update of that register. This happens at burst acceptance, when the flags of the control word change, and at transfer acceptance, when the count is decremented. The bench provokes both by driving `reg_wr` in exactly the cycle of the handshake. It judges the result by reading the register back afterwards, and expects the hardware value rather than the written one. Randomised bursts also mix register rewrites between bursts with table-fetch and transfer stalls of random length.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_TBL_REQ  = 2'd1,
      ST_TBL_WAIT = 2'd2,
      ST_XFER     = 2'd3
   } dxc_state_e;

   localparam int unsigned CTL_EN   = 0;
   localparam int unsigned CTL_DIR  = 1;
   localparam int unsigned CTL_TC   = 8;
   localparam int unsigned CTL_MERR = 9;
   localparam int unsigned CTL_AERR = 10;

   localparam logic [2:0] SEL_CTRL  = 3'd0;
   localparam logic [2:0] SEL_CNT   = 3'd1;
   localparam logic [2:0] SEL_LADDR = 3'd2;
   localparam logic [2:0] SEL_BASE  = 3'd3;
   localparam logic [2:0] SEL_LIMIT = 3'd4;
endpackage

// File: rtl/dxc_regs.sv
module dxc_regs
   import dxc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LEN_W  = 16,
   parameter bit          RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ev_start,
   input  logic              ev_merr,
   input  logic              ev_aerr,
   input  logic              ev_done,
   input  logic [LEN_W-1:0]  done_len,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] cnt_q,
   output logic [DATA_W-1:0] laddr_q,
   output logic [DATA_W-1:0] base_q,
   output logic [DATA_W-1:0] limit_q
);
   logic              hw_ctrl;
   logic [DATA_W-1:0] ctrl_hw;
   logic [DATA_W-1:0] rd_mux;

   assign hw_ctrl = ev_start | ev_aerr | ev_done;

   always_comb begin
      ctrl_hw = ctrl_q;
      if (ev_start) begin
         ctrl_hw[CTL_TC]   = 1'b0;
         ctrl_hw[CTL_MERR] = 1'b0;
         ctrl_hw[CTL_AERR] = 1'b0;
      end
      if (ev_merr) ctrl_hw[CTL_MERR] = 1'b1;
      if (ev_aerr) ctrl_hw[CTL_AERR] = 1'b1;
      if (ev_done) ctrl_hw[CTL_TC]   = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         cnt_q   <= '0;
         laddr_q <= '0;
         base_q  <= '0;
         limit_q <= '0;
      end else begin
         if (hw_ctrl)                            ctrl_q <= ctrl_hw;
         else if (reg_wr && reg_sel == SEL_CTRL) ctrl_q <= reg_wdata;
         if (ev_done)                            cnt_q  <= cnt_q - DATA_W'(done_len);
         else if (reg_wr && reg_sel == SEL_CNT)  cnt_q  <= reg_wdata;
         if (reg_wr && reg_sel == SEL_LADDR) laddr_q <= reg_wdata;
         if (reg_wr && reg_sel == SEL_BASE)  base_q  <= reg_wdata;
         if (reg_wr && reg_sel == SEL_LIMIT) limit_q <= reg_wdata;
      end
   end

   always_comb begin
      unique case (reg_sel)
         SEL_CTRL:  rd_mux = ctrl_q;
         SEL_CNT:   rd_mux = cnt_q;
         SEL_LADDR: rd_mux = laddr_q;
         SEL_BASE:  rd_mux = base_q;
         SEL_LIMIT: rd_mux = limit_q;
         default:   rd_mux = '0;
      endcase
   end

   generate
      if (RD_REG) begin : g_rd_flop
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign reg_rdata = rd_q;
      end else begin : g_rd_comb
         assign reg_rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/dxc_xlat.sv
module dxc_xlat #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned PAGE_BITS   = 12,
   parameter int unsigned ENTRY_SHIFT = 3,
   parameter int unsigned BASE_KEEP   = 31
) (
   input  logic [DATA_W-1:0] laddr,
   input  logic [DATA_W-1:0] base,
   input  logic [DATA_W-1:0] limit,
   input  logic [DATA_W-1:0] entry_word,
   input  logic [DATA_W-1:0] page_off,
   output logic              idx_ok,
   output logic [DATA_W-1:0] entry_addr,
   output logic [DATA_W-1:0] phys_addr
);
   localparam logic [DATA_W-1:0] PAGE_MASK = DATA_W'((64'd1 << PAGE_BITS) - 64'd1);
   localparam logic [DATA_W-1:0] BASE_MASK = DATA_W'((64'd1 << BASE_KEEP) - 64'd1);

   logic [DATA_W-1:0] page_idx;
   logic [DATA_W-1:0] n_entries;

   assign page_idx   = laddr >> PAGE_BITS;
   assign n_entries  = limit >> ENTRY_SHIFT;
   assign idx_ok     = page_idx < n_entries;
   assign entry_addr = (base & BASE_MASK) + (page_idx << ENTRY_SHIFT);
   assign phys_addr  = (entry_word & ~PAGE_MASK) | (page_off & PAGE_MASK);
endmodule

// File: rtl/dxc_fsm.sv
module dxc_fsm
   import dxc_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned PAGE_BITS = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_to_dev,
   input  logic [LEN_W-1:0]  req_len,
   output logic              req_ready,
   input  logic              ctl_en,
   input  logic              ctl_dir,
   input  logic [DATA_W-1:0] cnt,
   input  logic [DATA_W-1:0] laddr,
   input  logic              idx_ok,
   input  logic [DATA_W-1:0] entry_addr,
   input  logic [DATA_W-1:0] phys_addr,
   output logic [DATA_W-1:0] page_off,
   output logic              tbl_rd_valid,
   input  logic              tbl_rd_ready,
   output logic [DATA_W-1:0] tbl_rd_addr,
   input  logic              tbl_rsp_valid,
   input  logic              tbl_rsp_err,
   output logic              xfer_valid,
   input  logic              xfer_ready,
   output logic [DATA_W-1:0] xfer_addr,
   output logic [LEN_W-1:0]  xfer_len,
   output logic              xfer_to_dev,
   output logic              chan_err,
   output logic              ev_start,
   output logic              ev_merr,
   output logic              ev_aerr,
   output logic              ev_done
);
   localparam logic [DATA_W-1:0] PAGE_MASK = DATA_W'((64'd1 << PAGE_BITS) - 64'd1);

   dxc_state_e        state_q;
   logic              accept;
   logic              chk_ok;
   logic [LEN_W-1:0]  clip_len;
   logic [DATA_W-1:0] tbl_addr_q;
   logic [DATA_W-1:0] off_q;
   logic [DATA_W-1:0] xaddr_q;
   logic [LEN_W-1:0]  len_q;
   logic              dir_q;
   logic              err_q;
   logic              rsp_take;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign chk_ok    = ctl_en && (ctl_dir == req_to_dev);
   assign clip_len  = (cnt < DATA_W'(req_len)) ? cnt[LEN_W-1:0] : req_len;
   assign rsp_take  = (state_q == ST_TBL_WAIT) && tbl_rsp_valid;

   assign ev_start = accept;
   assign ev_merr  = accept && !chk_ok;
   assign ev_aerr  = (accept && chk_ok && !idx_ok) || (rsp_take && tbl_rsp_err);
   assign ev_done  = xfer_valid && xfer_ready;

   assign page_off     = off_q;
   assign tbl_rd_valid = (state_q == ST_TBL_REQ);
   assign tbl_rd_addr  = tbl_addr_q;
   assign xfer_valid   = (state_q == ST_XFER);
   assign xfer_addr    = xaddr_q;
   assign xfer_len     = len_q;
   assign xfer_to_dev  = dir_q;
   assign chan_err     = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         tbl_addr_q <= '0;
         off_q      <= '0;
         xaddr_q    <= '0;
         len_q      <= '0;
         dir_q      <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         err_q <= accept && !chk_ok;
         unique case (state_q)
            ST_IDLE: begin
               if (accept && chk_ok && idx_ok) begin
                  state_q    <= ST_TBL_REQ;
                  tbl_addr_q <= entry_addr;
                  off_q      <= laddr & PAGE_MASK;
                  len_q      <= clip_len;
                  dir_q      <= req_to_dev;
               end
            end
            ST_TBL_REQ: begin
               if (tbl_rd_ready) state_q <= ST_TBL_WAIT;
            end
            ST_TBL_WAIT: begin
               if (rsp_take) begin
                  if (tbl_rsp_err) begin
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_XFER;
                     xaddr_q <= phys_addr;
                  end
               end
            end
            ST_XFER: begin
               if (xfer_ready) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dma_xlat_channel.sv
module dma_xlat_channel
   import dxc_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned LEN_W       = 16,
   parameter int unsigned PAGE_BITS   = 12,
   parameter int unsigned ENTRY_BYTES = 8,
   parameter int unsigned BASE_KEEP   = 31,
   parameter bit          RD_REG      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_to_dev,
   input  logic [LEN_W-1:0]  req_len,
   output logic              tbl_rd_valid,
   input  logic              tbl_rd_ready,
   output logic [DATA_W-1:0] tbl_rd_addr,
   input  logic              tbl_rsp_valid,
   input  logic              tbl_rsp_err,
   input  logic [DATA_W-1:0] tbl_rsp_data,
   output logic              xfer_valid,
   input  logic              xfer_ready,
   output logic [DATA_W-1:0] xfer_addr,
   output logic [LEN_W-1:0]  xfer_len,
   output logic              xfer_to_dev,
   output logic              chan_err
);
   localparam int unsigned ENTRY_SHIFT = $clog2(ENTRY_BYTES);

   if (DATA_W < 16 || DATA_W > 64) begin : g_bad_data_w
      $error("dma_xlat_channel: DATA_W out of range");
   end
   if (LEN_W > DATA_W) begin : g_bad_len_w
      $error("dma_xlat_channel: LEN_W wider than DATA_W");
   end
   if (PAGE_BITS >= DATA_W || BASE_KEEP > DATA_W) begin : g_bad_page
      $error("dma_xlat_channel: PAGE_BITS or BASE_KEEP does not fit DATA_W");
   end
   if ((1 << ENTRY_SHIFT) != ENTRY_BYTES) begin : g_bad_entry
      $error("dma_xlat_channel: ENTRY_BYTES must be a power of two");
   end
   if (CTL_AERR >= DATA_W) begin : g_bad_ctl
      $error("dma_xlat_channel: control flags do not fit DATA_W");
   end

   logic [DATA_W-1:0] ctrl_q, cnt_q, laddr_q, base_q, limit_q;
   logic              ev_start, ev_merr, ev_aerr, ev_done;
   logic              idx_ok;
   logic [DATA_W-1:0] entry_addr, phys_addr, page_off;

   dxc_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W), .RD_REG(RD_REG)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_start(ev_start), .ev_merr(ev_merr), .ev_aerr(ev_aerr), .ev_done(ev_done),
      .done_len(xfer_len),
      .ctrl_q(ctrl_q), .cnt_q(cnt_q), .laddr_q(laddr_q), .base_q(base_q), .limit_q(limit_q)
   );

   dxc_xlat #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .ENTRY_SHIFT(ENTRY_SHIFT),
              .BASE_KEEP(BASE_KEEP)) u_xlat (
      .laddr(laddr_q), .base(base_q), .limit(limit_q),
      .entry_word(tbl_rsp_data), .page_off(page_off),
      .idx_ok(idx_ok), .entry_addr(entry_addr), .phys_addr(phys_addr)
   );

   dxc_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_to_dev(req_to_dev), .req_len(req_len), .req_ready(req_ready),
      .ctl_en(ctrl_q[CTL_EN]), .ctl_dir(ctrl_q[CTL_DIR]), .cnt(cnt_q), .laddr(laddr_q),
      .idx_ok(idx_ok), .entry_addr(entry_addr), .phys_addr(phys_addr), .page_off(page_off),
      .tbl_rd_valid(tbl_rd_valid), .tbl_rd_ready(tbl_rd_ready), .tbl_rd_addr(tbl_rd_addr),
      .tbl_rsp_valid(tbl_rsp_valid), .tbl_rsp_err(tbl_rsp_err),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
      .xfer_len(xfer_len), .xfer_to_dev(xfer_to_dev), .chan_err(chan_err),
      .ev_start(ev_start), .ev_merr(ev_merr), .ev_aerr(ev_aerr), .ev_done(ev_done)
   );
endmodule

// File: rtl/dxc_checker.sv
module dxc_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LEN_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              tbl_rd_valid,
   input logic              tbl_rd_ready,
   input logic [DATA_W-1:0] tbl_rd_addr,
   input logic              xfer_valid,
   input logic              xfer_ready,
   input logic [DATA_W-1:0] xfer_addr,
   input logic [LEN_W-1:0]  xfer_len,
   input logic              chan_err,
   input logic [DATA_W-1:0] ctrl_q,
   input logic [DATA_W-1:0] cnt_q
);
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_rd_valid || xfer_valid) |-> !req_ready); // R3
   AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      chan_err |-> $past(req_valid && req_ready)); // R4
   AST_ERR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      chan_err |-> ctrl_q[9]); // R4
   AST_TBL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_rd_valid && !tbl_rd_ready) |=> (tbl_rd_valid && $stable(tbl_rd_addr))); // R10
   AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_len))); // R10
   AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tbl_rd_valid, xfer_valid})); // R10
   AST_COUNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_ready) |=> (cnt_q == $past(cnt_q) - DATA_W'($past(xfer_len)))); // R9
   AST_TC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_ready) |=> ctrl_q[8]); // R9
endmodule

bind dma_xlat_channel dxc_checker #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .tbl_rd_valid(tbl_rd_valid), .tbl_rd_ready(tbl_rd_ready), .tbl_rd_addr(tbl_rd_addr),
   .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
   .xfer_len(xfer_len), .chan_err(chan_err), .ctrl_q(ctrl_q), .cnt_q(cnt_q)
);

// File: tb/dma_xlat_channel_test.sv
module dma_xlat_channel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_to_dev = 1'b0;
   logic [15:0] req_len = '0;
   logic        tbl_rd_valid;
   logic        tbl_rd_ready = 1'b0;
   logic [31:0] tbl_rd_addr;
   logic        tbl_rsp_valid = 1'b0;
   logic        tbl_rsp_err = 1'b0;
   logic [31:0] tbl_rsp_data = '0;
   logic        xfer_valid;
   logic        xfer_ready = 1'b0;
   logic [31:0] xfer_addr;
   logic [15:0] xfer_len;
   logic        xfer_to_dev;
   logic        chan_err;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;
   logic [31:0] s_ctrl = '0, s_cnt = '0, s_laddr = '0, s_base = '0, s_limit = '0;

   dma_xlat_channel uut (.*);

   always #5 clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   function automatic logic [31:0] entry_word(input logic [31:0] a);
      return (a * 32'h9E3779B1) ^ 32'h5A5A0123;
   endfunction

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      case (sel)
         3'd0: s_ctrl = d;
         3'd1: s_cnt = d;
         3'd2: s_laddr = d;
         3'd3: s_base = d;
         3'd4: s_limit = d;
         default: ;
      endcase
   endtask

   task automatic rd(input logic [2:0] sel, output logic [31:0] d);
      @(negedge clk);
      reg_sel = sel;
      #1 d = reg_rdata;
   endtask

   // collide: 0 none, 1 count write at transfer handshake, 2 control write at acceptance
   task automatic burst(input bit to_dev, input logic [15:0] len, input bit rsp_err, input int collide);
      logic [31:0] idx, lim, eaddr, ew, exp_x, v;
      logic [15:0] clip;
      bit merr, aerr_idx, got, hs, first;
      merr = !s_ctrl[0] || (s_ctrl[1] != to_dev);
      idx = s_laddr >> 12;
      lim = s_limit >> 3;
      aerr_idx = !merr && !(idx < lim);
      eaddr = (s_base & 32'h7FFFFFFF) + (idx << 3);
      ew = entry_word(eaddr);
      clip = (s_cnt < {16'b0, len}) ? s_cnt[15:0] : len;
      s_ctrl[10:8] = 3'b000;
      @(negedge clk);
      check(req_ready === 1'b1, "R3 ready while idle", {31'b0, req_ready}, 32'd1);
      req_valid = 1'b1; req_to_dev = to_dev; req_len = len;
      if (collide == 2) begin
         reg_wr = 1'b1; reg_sel = 3'd0; reg_wdata = 32'hFFFF_FFFF; // R11
      end
      @(negedge clk);
      req_valid = 1'b0; reg_wr = 1'b0;
      check(chan_err === merr, "R4 error pulse after acceptance", {31'b0, chan_err}, {31'b0, merr});
      if (merr || aerr_idx) begin
         for (int c = 0; c < 3; c++) begin
            check(!tbl_rd_valid && !xfer_valid, merr ? "R4 no access on error" : "R5 no table read out of range",
                  {30'b0, tbl_rd_valid, xfer_valid}, 32'd0);
            @(negedge clk);
         end
         s_ctrl[9] = merr;
         s_ctrl[10] = aerr_idx;
      end else begin
         got = 0; first = 1;
         for (int c = 0; c < 60 && !got; c++) begin
            hs = 0;
            if (tbl_rd_valid) begin
               if (first) check(tbl_rd_addr === eaddr, "R6 table entry address", tbl_rd_addr, eaddr);
               else       check(tbl_rd_addr === eaddr, "R10 table address held", tbl_rd_addr, eaddr);
               first = 0;
               tbl_rd_ready = ($urandom % 3) != 0;
               hs = tbl_rd_ready;
            end
            @(negedge clk);
            tbl_rd_ready = 1'b0;
            if (hs) got = 1;
         end
         check(got, "R6 table read issued", {31'b0, got}, 32'd1);
         repeat ($urandom % 3) @(negedge clk);
         tbl_rsp_valid = 1'b1; tbl_rsp_err = rsp_err;
         tbl_rsp_data = rsp_err ? 32'hDEAD_0000 : ew;
         @(negedge clk);
         tbl_rsp_valid = 1'b0; tbl_rsp_err = 1'b0;
         if (rsp_err) begin
            for (int c = 0; c < 3; c++) begin
               check(!xfer_valid, "R7 no transfer after table error", {31'b0, xfer_valid}, 32'd0);
               @(negedge clk);
            end
            s_ctrl[10] = 1'b1;
         end else begin
            exp_x = (ew & 32'hFFFF_F000) | (s_laddr & 32'h0000_0FFF);
            got = 0; first = 1;
            for (int c = 0; c < 60 && !got; c++) begin
               hs = 0;
               if (xfer_valid) begin
                  if (first) begin
                     check(xfer_addr === exp_x, "R8 physical address", xfer_addr, exp_x);
                     check(xfer_len === clip, "R8 clipped length", {16'b0, xfer_len}, {16'b0, clip});
                     check(xfer_to_dev === to_dev, "R8 direction", {31'b0, xfer_to_dev}, {31'b0, to_dev});
                  end else begin
                     check(xfer_addr === exp_x, "R10 transfer address held", xfer_addr, exp_x);
                  end
                  first = 0;
                  xfer_ready = ($urandom % 3) != 0;
                  hs = xfer_ready;
                  if (hs && collide == 1) begin
                     reg_wr = 1'b1; reg_sel = 3'd1; reg_wdata = 32'h0BAD_F00D; // R11
                  end
               end
               @(negedge clk);
               xfer_ready = 1'b0; reg_wr = 1'b0;
               if (hs) got = 1;
            end
            check(got, "R9 transfer issued", {31'b0, got}, 32'd1);
            s_cnt = s_cnt - {16'b0, clip};
            s_ctrl[8] = 1'b1;
         end
      end
      check(req_ready === 1'b1, "R3 idle after burst", {31'b0, req_ready}, 32'd1);
      rd(3'd0, v);
      check(v === s_ctrl, collide == 2 ? "R11 control kept over write" : "R9 control flags", v, s_ctrl);
      rd(3'd1, v);
      check(v === s_cnt, collide == 1 ? "R11 count kept over write" : "R9 remaining count", v, s_cnt);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int s = 0; s < 5; s++) begin
         rd(3'(s), v);
         check(v === 32'd0, "R1 register zero after reset", v, 32'd0);
      end
      check(req_ready === 1'b1 && chan_err === 1'b0 && tbl_rd_valid === 1'b0 && xfer_valid === 1'b0,
            "R1 outputs after reset", {28'b0, req_ready, chan_err, tbl_rd_valid, xfer_valid}, 32'h8);
      // R2 write and read back
      wr(3'd0, 32'h0000_0001);
      wr(3'd1, 32'd1000);
      wr(3'd2, 32'h0000_3456);
      wr(3'd3, 32'h8000_1000);
      wr(3'd4, 32'd32);
      rd(3'd0, v); check(v === s_ctrl,  "R2 control readback", v, s_ctrl);
      rd(3'd1, v); check(v === s_cnt,   "R2 count readback", v, s_cnt);
      rd(3'd2, v); check(v === s_laddr, "R2 logical address readback", v, s_laddr);
      rd(3'd3, v); check(v === s_base,  "R2 table base readback", v, s_base);
      rd(3'd4, v); check(v === s_limit, "R2 table size readback", v, s_limit);
      // normal burst, last valid index (R5 boundary, R6, R8, R9)
      burst(1'b0, 16'd100, 1'b0, 0);
      // length above count is clipped, count write collides with transfer (R8, R11)
      burst(1'b0, 16'd2000, 1'b0, 1);
      // zero count: zero-length transfer still completes (R8, R9)
      burst(1'b0, 16'd5, 1'b0, 0);
      // disabled channel (R4)
      wr(3'd0, 32'h0000_0000);
      burst(1'b0, 16'd8, 1'b0, 0);
      // direction mismatch (R4)
      wr(3'd0, 32'h0000_0001);
      burst(1'b1, 16'd8, 1'b0, 0);
      // memory to device, control write collides with acceptance (R11)
      wr(3'd0, 32'h0000_0003);
      wr(3'd1, 32'd50);
      burst(1'b1, 16'd20, 1'b0, 2);
      // first index past the table (R5)
      wr(3'd2, 32'h0000_4000);
      burst(1'b1, 16'd4, 1'b0, 0);
      // empty table (R5)
      wr(3'd4, 32'd0);
      wr(3'd2, 32'h0000_0010);
      burst(1'b1, 16'd4, 1'b0, 0);
      // table read error (R7)
      wr(3'd4, 32'd40);
      wr(3'd2, 32'h0000_4FFF);
      burst(1'b1, 16'd4, 1'b1, 0);
      // randomised bursts
      for (int i = 0; i < 40; i++) begin
         bit dir;
         dir = $urandom % 2;
         wr(3'd0, ($urandom & 32'hFFFF_F8FC) | {30'b0, dir, (($urandom % 6) != 0)});
         wr(3'd1, $urandom % 600);
         wr(3'd2, (($urandom % 40) << 12) | ($urandom & 32'hFFF));
         wr(3'd3, $urandom);
         wr(3'd4, $urandom % 320);
         burst((($urandom % 5) != 0) ? dir : ~dir, 16'($urandom % 700), ($urandom % 8) == 0,
               int'($urandom % 3));
      end
      finish_run();
   end
endmodule